// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block keeps a short history of serviced interrupts so that the time from request to service can be measured in hardware. Each interrupt source has an id. When the request line for an id goes from low to high, the block records the value of a free-running 64-bit cycle counter as that id's request time. When the processor accepts an interrupt, it pulses a take strobe with the accepted id. The block then writes one history entry that holds the id, the current cycle (the service time) and the request time last recorded for that id.

Entries go into a circular buffer of parameterised depth. A read port addresses the history newest-first. For the addressed entry it returns the id, the service cycle, the latency (service minus request), and the gap to the next-newer entry's service cycle. An entry whose service cycle is zero has never been written, which marks the end of valid history.

A separate counter totals raised interrupts. It advances once for each accepted interrupt and once for each direct software raise.

Top module: `irq_latency_history`

## Requirements
- R1: A low-to-high transition of `raise_vec[i]` at a clock edge stores `cycle_now` as the request time of id i. Any number of ids can be stamped at the same edge. While a line stays high, its stamp is not changed.
- R2: A clock edge with `take_valid` high writes one entry holding `take_id`, `cycle_now` as the service cycle, and the request time that id held before that edge. A rise of the same id at the same edge does not reach this entry.
- R3: The write slot advances by one after each write and wraps from DEPTH-1 to 0. Without a write it holds its value.
- R4: Read index k addresses slot (write_slot - k - 1) mod DEPTH, so k = 0 is the newest entry. Read results appear at the clock edge after `rd_idx` is applied and reflect the buffer state before that edge.
- R5: `rd_latency` is the service cycle minus the request cycle. `rd_gap_valid` is 1 only when k is not 0 and the entry is valid. In that case `rd_gap` is the next-newer entry's service cycle minus this entry's service cycle; otherwise `rd_gap` is 0.
- R6: `rd_valid` is 1 exactly when the addressed entry's service cycle is non-zero. Reset clears all entries, the write slot, the request times, the counter and the read outputs.
- R7: At each edge `raise_count` increases by `take_valid` plus `soft_raise`, so by 0, 1 or 2.
- R8: Taking an id that has never been requested since reset gives a request time of 0, so the latency equals the service cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_now | input | CYC_W | Free-running cycle count |
| raise_vec | input | NUM_IDS | Per-id request levels; each rise is stamped |
| soft_raise | input | 1 | Direct software raise pulse (counted only) |
| take_valid | input | 1 | Interrupt accepted this cycle |
| take_id | input | ID_W | Id of the accepted interrupt |
| rd_idx | input | PTR_W | Newest-first history index |
| rd_valid | output | 1 | Addressed entry holds data |
| rd_id | output | ID_W | Id of the addressed entry |
| rd_taken | output | CYC_W | Service cycle of the addressed entry |
| rd_latency | output | CYC_W | Service minus request cycle |
| rd_gap_valid | output | 1 | A newer entry exists for the gap |
| rd_gap | output | CYC_W | Newer service cycle minus this service cycle |
| raise_count | output | CNT_W | Running total of raised interrupts |

## Verification
Request stamps, entry writes and the counter all update at the edge where their inputs are sampled. The read outputs are registered, so they become valid one edge after `rd_idx` is applied and show the buffer as it was before that edge. For every cycle the bench computes the expected read result from its own model state before the edge, updates the model with the inputs it drove, and compares both the read outputs and `raise_count` at the following falling edge. This keeps a write in the same cycle as a read from shifting the expected slot.

// File: rtl/irq_hist_pkg.sv
package irq_hist_pkg;

  // Physical slot of the k-th newest entry given the next write slot.
  function automatic int unsigned ring_slot(input int unsigned wr,
                                            input int unsigned k,
                                            input int unsigned depth);
    return (wr + 2 * depth - 1 - k) % depth;
  endfunction

endpackage

// File: rtl/irq_raise_stamp.sv
module irq_raise_stamp #(
  parameter int unsigned NUM_IDS = 8,
  parameter int unsigned ID_W    = 3,
  parameter int unsigned CYC_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYC_W-1:0]   cycle_now,
  input  logic [NUM_IDS-1:0] raise_vec,
  input  logic [ID_W-1:0]    lookup_id,
  output logic [CYC_W-1:0]   lookup_stamp
);

  logic [NUM_IDS-1:0] prev_q;
  logic [NUM_IDS-1:0] rise;
  logic [CYC_W-1:0]   stamp_q [NUM_IDS];

  assign rise = raise_vec & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      for (int i = 0; i < int'(NUM_IDS); i++) stamp_q[i] <= '0;
    end else begin
      prev_q <= raise_vec;
      for (int i = 0; i < int'(NUM_IDS); i++) begin
        if (rise[i]) stamp_q[i] <= cycle_now;
      end
    end
  end

  assign lookup_stamp = stamp_q[lookup_id];

endmodule

// File: rtl/irq_hist_ring.sv
module irq_hist_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned CYC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [CYC_W-1:0] wr_taken,
  input  logic [CYC_W-1:0] wr_raised,
  output logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] slot_own,
  input  logic [PTR_W-1:0] slot_newer,
  output logic [ID_W-1:0]  own_id,
  output logic [CYC_W-1:0] own_taken,
  output logic [CYC_W-1:0] own_raised,
  output logic [CYC_W-1:0] newer_taken
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  id_mem [DEPTH];
  logic [CYC_W-1:0] tk_mem [DEPTH];
  logic [CYC_W-1:0] rs_mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        id_mem[i] <= '0;
        tk_mem[i] <= '0;
        rs_mem[i] <= '0;
      end
    end else if (wr_en) begin
      id_mem[ptr_q] <= wr_id;
      tk_mem[ptr_q] <= wr_taken;
      rs_mem[ptr_q] <= wr_raised;
      ptr_q         <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign wr_ptr      = ptr_q;
  assign own_id      = id_mem[slot_own];
  assign own_taken   = tk_mem[slot_own];
  assign own_raised  = rs_mem[slot_own];
  assign newer_taken = tk_mem[slot_newer];

endmodule

// File: rtl/irq_hist_reader.sv
module irq_hist_reader
  import irq_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned CYC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] slot_own,
  output logic [PTR_W-1:0] slot_newer,
  input  logic [ID_W-1:0]  own_id,
  input  logic [CYC_W-1:0] own_taken,
  input  logic [CYC_W-1:0] own_raised,
  input  logic [CYC_W-1:0] newer_taken,
  output logic             rd_valid,
  output logic [ID_W-1:0]  rd_id,
  output logic [CYC_W-1:0] rd_taken,
  output logic [CYC_W-1:0] rd_latency,
  output logic             rd_gap_valid,
  output logic [CYC_W-1:0] rd_gap
);

  logic [PTR_W-1:0] idx_newer;
  logic             own_valid;
  logic             gap_ok;

  always_comb begin
    idx_newer  = (rd_idx == '0) ? '0 : rd_idx - PTR_W'(1);
    slot_own   = PTR_W'(ring_slot(32'(wr_ptr), 32'(rd_idx), DEPTH));
    slot_newer = PTR_W'(ring_slot(32'(wr_ptr), 32'(idx_newer), DEPTH));
    own_valid  = (own_taken != '0);
    gap_ok     = own_valid && (rd_idx != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      rd_id        <= '0;
      rd_taken     <= '0;
      rd_latency   <= '0;
      rd_gap_valid <= 1'b0;
      rd_gap       <= '0;
    end else begin
      rd_valid     <= own_valid;
      rd_id        <= own_id;
      rd_taken     <= own_taken;
      rd_latency   <= own_taken - own_raised;
      rd_gap_valid <= gap_ok;
      rd_gap       <= gap_ok ? (newer_taken - own_taken) : '0;
    end
  end

endmodule

// File: rtl/irq_latency_history.sv
module irq_latency_history #(
  parameter int unsigned NUM_IDS = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CYC_W   = 64,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ID_W    = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
  parameter int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CYC_W-1:0]   cycle_now,
  input  logic [NUM_IDS-1:0] raise_vec,
  input  logic               soft_raise,
  input  logic               take_valid,
  input  logic [ID_W-1:0]    take_id,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [ID_W-1:0]    rd_id,
  output logic [CYC_W-1:0]   rd_taken,
  output logic [CYC_W-1:0]   rd_latency,
  output logic               rd_gap_valid,
  output logic [CYC_W-1:0]   rd_gap,
  output logic [CNT_W-1:0]   raise_count
);

  logic [CYC_W-1:0] take_stamp;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] slot_own;
  logic [PTR_W-1:0] slot_newer;
  logic [ID_W-1:0]  own_id;
  logic [CYC_W-1:0] own_taken;
  logic [CYC_W-1:0] own_raised;
  logic [CYC_W-1:0] newer_taken;
  logic [CNT_W-1:0] count_q;

  irq_raise_stamp #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .CYC_W(CYC_W)) u_stamp (
    .clk          (clk),
    .rst          (rst),
    .cycle_now    (cycle_now),
    .raise_vec    (raise_vec),
    .lookup_id    (take_id),
    .lookup_stamp (take_stamp)
  );

  irq_hist_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ID_W(ID_W), .CYC_W(CYC_W)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (take_valid),
    .wr_id       (take_id),
    .wr_taken    (cycle_now),
    .wr_raised   (take_stamp),
    .wr_ptr      (wr_ptr),
    .slot_own    (slot_own),
    .slot_newer  (slot_newer),
    .own_id      (own_id),
    .own_taken   (own_taken),
    .own_raised  (own_raised),
    .newer_taken (newer_taken)
  );

  irq_hist_reader #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ID_W(ID_W), .CYC_W(CYC_W)) u_read (
    .clk          (clk),
    .rst          (rst),
    .wr_ptr       (wr_ptr),
    .rd_idx       (rd_idx),
    .slot_own     (slot_own),
    .slot_newer   (slot_newer),
    .own_id       (own_id),
    .own_taken    (own_taken),
    .own_raised   (own_raised),
    .newer_taken  (newer_taken),
    .rd_valid     (rd_valid),
    .rd_id        (rd_id),
    .rd_taken     (rd_taken),
    .rd_latency   (rd_latency),
    .rd_gap_valid (rd_gap_valid),
    .rd_gap       (rd_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + CNT_W'(take_valid) + CNT_W'(soft_raise);
  end

  assign raise_count = count_q;

endmodule

// File: rtl/irq_latency_history_chk.sv
module irq_latency_history_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             take_valid,
  input logic             soft_raise,
  input logic [PTR_W-1:0] rd_idx,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [CNT_W-1:0] raise_count,
  input logic             rd_valid,
  input logic             rd_gap_valid
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take_valid && wr_ptr == PTR_W'(DEPTH - 1)) |=> (wr_ptr == '0)); // R3

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take_valid |=> $stable(wr_ptr)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (raise_count == $past(raise_count) + CNT_W'($past(take_valid))
                 + CNT_W'($past(soft_raise)))); // R7

  AST_GAP_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rd_idx) == '0) |-> !rd_gap_valid); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (raise_count == '0 && wr_ptr == '0 && !rd_valid && !rd_gap_valid)); // R6

endmodule

bind irq_latency_history irq_latency_history_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .take_valid   (take_valid),
  .soft_raise   (soft_raise),
  .rd_idx       (rd_idx),
  .wr_ptr       (wr_ptr),
  .raise_count  (raise_count),
  .rd_valid     (rd_valid),
  .rd_gap_valid (rd_gap_valid)
);

// File: tb/tb_irq_latency_history.sv
`timescale 1ns/1ps
module tb_irq_latency_history;

  localparam int NID = 8;
  localparam int DP  = 8;
  localparam int IW  = 3;
  localparam int PW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   cycle_now = 64'd0;
  logic [NID-1:0] raise_vec = '0;
  logic          soft_raise = 1'b0;
  logic          take_valid = 1'b0;
  logic [IW-1:0] take_id = '0;
  logic [PW-1:0] rd_idx = '0;
  logic          rd_valid, rd_gap_valid;
  logic [IW-1:0] rd_id;
  logic [63:0]   rd_taken, rd_latency, rd_gap;
  logic [31:0]   raise_count;

  always #2.5 clk = ~clk;

  irq_latency_history dut (
    .clk(clk), .rst(rst), .cycle_now(cycle_now), .raise_vec(raise_vec),
    .soft_raise(soft_raise), .take_valid(take_valid), .take_id(take_id),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_id(rd_id), .rd_taken(rd_taken),
    .rd_latency(rd_latency), .rd_gap_valid(rd_gap_valid), .rd_gap(rd_gap),
    .raise_count(raise_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [NID-1:0] m_prev;
  logic [63:0]    m_stamp [NID];
  logic [IW-1:0]  m_id [DP];
  logic [63:0]    m_tk [DP];
  logic [63:0]    m_rs [DP];
  int             m_wr;
  logic [31:0]    m_cnt;

  task automatic model_clear();
    m_prev = '0; m_wr = 0; m_cnt = 0;
    for (int i = 0; i < NID; i++) m_stamp[i] = 0;
    for (int i = 0; i < DP; i++) begin m_id[i] = 0; m_tk[i] = 0; m_rs[i] = 0; end
  endtask

  function automatic int slot_of(int wr, int k);
    return (wr + 2 * DP - 1 - k) % DP;
  endfunction

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // One clock: predict read result from pre-edge model, update model, compare.
  task automatic step(string tag);
    int k, s, ns;
    logic ev, egv;
    logic [IW-1:0] eid;
    logic [63:0] etk, elat, egap;
    k  = int'(rd_idx);
    s  = slot_of(m_wr, k);
    ns = slot_of(m_wr, (k == 0) ? 0 : k - 1);
    ev = (m_tk[s] != 0);
    eid = m_id[s]; etk = m_tk[s]; elat = m_tk[s] - m_rs[s];
    egv = ev && (k != 0);
    egap = egv ? (m_tk[ns] - m_tk[s]) : 64'd0;
    @(posedge clk);
    if (rst) begin
      model_clear();
      ev = 0; eid = 0; etk = 0; elat = 0; egv = 0; egap = 0;
    end else begin
      if (take_valid) begin
        m_id[m_wr] = take_id; m_tk[m_wr] = cycle_now;
        m_rs[m_wr] = m_stamp[take_id];
        m_wr = (m_wr + 1) % DP;
      end
      for (int i = 0; i < NID; i++)
        if (raise_vec[i] && !m_prev[i]) m_stamp[i] = cycle_now;
      m_prev = raise_vec;
      m_cnt = m_cnt + 32'(take_valid) + 32'(soft_raise);
    end
    @(negedge clk);
    checks++;
    if (rd_valid !== ev)       fail_line(tag, "R6 rd_valid", 64'(rd_valid), 64'(ev));
    if (rd_id !== eid)         fail_line(tag, "R2/R4 rd_id", 64'(rd_id), 64'(eid));
    if (rd_taken !== etk)      fail_line(tag, "R2/R4 rd_taken", rd_taken, etk);
    if (rd_latency !== elat)   fail_line(tag, "R5 rd_latency", rd_latency, elat);
    if (rd_gap_valid !== egv)  fail_line(tag, "R5 rd_gap_valid", 64'(rd_gap_valid), 64'(egv));
    if (rd_gap !== egap)       fail_line(tag, "R5 rd_gap", rd_gap, egap);
    checks++;
    if (raise_count !== m_cnt) fail_line(tag, "R7 raise_count", 64'(raise_count), 64'(m_cnt));
    cycle_now = cycle_now + 64'($urandom_range(1, 3));
  endtask

  task automatic idle(string tag, int n);
    take_valid = 0; soft_raise = 0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic take(string tag, int id);
    take_valid = 1; take_id = IW'(id);
    step(tag);
    take_valid = 0;
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < DP; k++) begin rd_idx = PW'(k); step(tag); end
    rd_idx = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    cycle_now = 64'd10;
    @(negedge clk);
    rst = 1;
    idle("R6", 3);              // reset state
    rst = 0;
    idle("R6", 2);
    sweep("R6");                // all invalid after reset

    take("R8", 5);              // never-requested id: latency == taken
    idle("R8", 1);

    raise_vec[2] = 1; raise_vec[6] = 1;
    idle("R1", 1);              // both stamped at same edge
    idle("R1", 4);              // held high: no restamp
    take("R1", 2);
    take("R1", 6);
    rd_idx = 1; idle("R5", 2);  // gap between the two newest
    rd_idx = 0; idle("R5", 1);

    raise_vec[1] = 1;           // rise and take same edge: old stamp used
    take("R2", 1);
    idle("R2", 1);

    for (int i = 0; i < DP + 3; i++) take("R3", i % NID);
    rd_idx = PW'(DP - 1); idle("R3", 2);
    sweep("R4");

    soft_raise = 1; take("R7", 4); soft_raise = 0;
    idle("R7", 1);

    raise_vec = '0;
    for (int n = 0; n < 4000; n++) begin
      raise_vec  = NID'($urandom);
      take_valid = ($urandom_range(0, 9) < 4);
      take_id    = IW'($urandom);
      soft_raise = ($urandom_range(0, 9) < 2);
      rd_idx     = PW'($urandom);
      step("R4");
    end
    take_valid = 0; soft_raise = 0;

    rst = 1; idle("R6", 2); rst = 0;
    sweep("R6");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule